// File: doc/BRIEF.md
# Tag-Indexed Pipelined Word Sorter

This block takes a full set of 16 words, 32 bits each, on every clock cycle and returns the same words in ascending order of a small key field inside each word. Only short tags pass through the compare-exchange network. Each tag holds the key and the number of the input slot the word came from. While the tags are sorted, the full words wait in a register delay line whose length matches the network. A registered gather stage then uses the slot numbers in the sorted tags to pick the delayed words in their new order.

The network is a bitonic network with log2(N)·(log2(N)+1)/2 registered stages, which is 10 stages for 16 words. The gather stage adds one more register. A valid flag runs beside the data, so the block accepts a new set on every cycle and delivers one set per cycle once the pipeline is full. Two words with the same key keep the relative order they had at the input, because each tag compares as the full {key, slot} value. A parameter sets where the key sits inside the word.

Top module: `tag_sorter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid is 0.
- R2: out_valid equals in_valid from exactly 11 clock edges earlier with the default parameters. Gaps and isolated valid cycles keep their spacing.
- R3: In every valid output set, the key fields (bits [KEY_LSB+KEY_W-1:KEY_LSB] of each word) do not decrease from slot 0 (bits [31:0]) to slot 15 (bits [511:480]).
- R4: Words with equal keys come out in the order of their input slots, where a lower input slot comes first.
- R5: Every valid output set is a permutation of the matching input set, and every word passes through bit-for-bit unchanged.
- R6: Input sets presented on consecutive cycles come out on consecutive cycles, and no set affects another.
- R7: Only the key field at KEY_LSB sets the order. Bits outside that field, including the bits below it, have no effect on the output order.
- R8: When all 16 keys are equal, the output equals the input unchanged.
- R9: When the keys strictly decrease across the input slots, the output is the input with the slots fully reversed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks in_words as a set to be sorted in this cycle |
| in_words | input | NUM_WORDS*WORD_W | Input set; slot i occupies bits [i*WORD_W +: WORD_W] |
| out_valid | output | 1 | Marks out_words as a sorted set |
| out_words | output | NUM_WORDS*WORD_W | Sorted set; slot 0 holds the smallest key |

## Verification
The bench builds the block with 16 words of 32 bits, a 4-bit key and KEY_LSB set to 4 instead of the default 0. With the key away from the bottom of the word, the bench can place values below and above the key field that would sort differently if the block read the wrong bits, and this exercises R7. Because keys are only 4 bits wide across 16 slots, random sets contain many duplicate keys. The order among equal keys is therefore checked in almost every set, not only in the dedicated patterns.

// File: rtl/tagsort_pkg.sv
package tagsort_pkg;

    // Number of compare-exchange stages in a bitonic network of 2**lg inputs.
    function automatic int net_stages(input int lg);
        return (lg * (lg + 1)) / 2;
    endfunction

endpackage

// File: rtl/tagsort_cx_stage.sv
module tagsort_cx_stage #(
    parameter int N     = 16,
    parameter int TAG_W = 8,
    parameter int BLK   = 2,
    parameter int DIST  = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  logic [N-1:0][TAG_W-1:0]   in_tags,
    output logic                      out_vld,
    output logic [N-1:0][TAG_W-1:0]   out_tags
);

    typedef struct packed {
        logic                    vld;
        logic [N-1:0][TAG_W-1:0] tags;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d.vld  = in_vld;
        st_d.tags = in_tags;
        for (int i = 0; i < N; i++) begin
            int  partner;
            logic up, swap;
            partner = i ^ DIST;
            if (partner > i) begin
                up   = ((i & BLK) == 0);
                swap = up ? (in_tags[i] > in_tags[partner])
                          : (in_tags[i] < in_tags[partner]);
                if (swap) begin
                    st_d.tags[i]       = in_tags[partner];
                    st_d.tags[partner] = in_tags[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_tags = st_q.tags;

endmodule

// File: rtl/tagsort_word_delay.sv
module tagsort_word_delay #(
    parameter int N      = 16,
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N*WORD_W-1:0]   in_words,
    output logic [N*WORD_W-1:0]   out_words
);

    localparam int SET_W = N * WORD_W;

    generate
        if (DEPTH == 0) begin : g_bypass
            assign out_words = in_words;
        end else begin : g_line
            logic [DEPTH-1:0][SET_W-1:0] line_d, line_q;

            always_comb begin
                line_d[0] = in_words;
                for (int k = 1; k < DEPTH; k++) line_d[k] = line_q[k-1];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) line_q <= '0;
                else        line_q <= line_d;
            end

            assign out_words = line_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/tagsort_gather.sv
module tagsort_gather #(
    parameter int N      = 16,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [N-1:0][TAG_W-1:0]  in_tags,
    input  logic [N*WORD_W-1:0]      in_words,
    output logic                     out_vld,
    output logic [N*WORD_W-1:0]      out_words
);

    typedef struct packed {
        logic                  vld;
        logic [N*WORD_W-1:0]   words;
    } gather_t;

    gather_t st_d, st_q;

    always_comb begin
        st_d.vld   = in_vld;
        st_d.words = '0;
        for (int i = 0; i < N; i++) begin
            logic [IDX_W-1:0] src;
            src = in_tags[i][IDX_W-1:0];
            st_d.words[i*WORD_W +: WORD_W] = in_words[int'(src)*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld   = st_q.vld;
    assign out_words = st_q.words;

endmodule

// File: rtl/tag_sorter.sv
module tag_sorter #(
    parameter int NUM_WORDS = 16,
    parameter int WORD_W    = 32,
    parameter int KEY_W     = 4,
    parameter int KEY_LSB   = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [NUM_WORDS*WORD_W-1:0]   in_words,
    output logic                          out_valid,
    output logic [NUM_WORDS*WORD_W-1:0]   out_words
);

    localparam int IDX_W  = $clog2(NUM_WORDS);
    localparam int TAG_W  = KEY_W + IDX_W;
    localparam int STAGES = tagsort_pkg::net_stages(IDX_W);

    logic [NUM_WORDS-1:0][TAG_W-1:0] tag_w [STAGES+1];
    logic                            vld_w [STAGES+1];
    logic [NUM_WORDS*WORD_W-1:0]     dly_words;

    assign vld_w[0] = in_valid;

    generate
        for (genvar i = 0; i < NUM_WORDS; i++) begin : g_tag
            assign tag_w[0][i] = {in_words[i*WORD_W + KEY_LSB +: KEY_W], IDX_W'(i)};
        end

        for (genvar p = 1; p <= IDX_W; p++) begin : g_phase
            for (genvar r = 0; r < p; r++) begin : g_step
                localparam int S = (p * (p - 1)) / 2 + r;
                tagsort_cx_stage #(
                    .N     (NUM_WORDS),
                    .TAG_W (TAG_W),
                    .BLK   (1 << p),
                    .DIST  (1 << (p - 1 - r))
                ) u_stage (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .in_vld   (vld_w[S]),
                    .in_tags  (tag_w[S]),
                    .out_vld  (vld_w[S+1]),
                    .out_tags (tag_w[S+1])
                );
            end
        end
    endgenerate

    tagsort_word_delay #(
        .N      (NUM_WORDS),
        .WORD_W (WORD_W),
        .DEPTH  (STAGES)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_words  (in_words),
        .out_words (dly_words)
    );

    tagsort_gather #(
        .N      (NUM_WORDS),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (vld_w[STAGES]),
        .in_tags   (tag_w[STAGES]),
        .in_words  (dly_words),
        .out_vld   (out_valid),
        .out_words (out_words)
    );

endmodule

// File: rtl/tag_sorter_chk.sv
module tag_sorter_chk #(
    parameter int NUM_WORDS = 16,
    parameter int WORD_W    = 32,
    parameter int KEY_W     = 4,
    parameter int KEY_LSB   = 0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [NUM_WORDS*WORD_W-1:0]   in_words,
    input logic                          out_valid,
    input logic [NUM_WORDS*WORD_W-1:0]   out_words
);

    localparam int LAT = tagsort_pkg::net_stages($clog2(NUM_WORDS)) + 1;

    logic [LAT-1:0]             vpipe;
    logic [LAT-1:0][WORD_W-1:0] xpipe;
    logic [WORD_W-1:0]          in_x, out_x;
    logic                       asc_ok;

    always_comb begin
        in_x  = '0;
        out_x = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            in_x  = in_x  ^ in_words [i*WORD_W +: WORD_W];
            out_x = out_x ^ out_words[i*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        asc_ok = 1'b1;
        for (int i = 0; i < NUM_WORDS - 1; i++) begin
            if (out_words[i*WORD_W + KEY_LSB +: KEY_W] >
                out_words[(i+1)*WORD_W + KEY_LSB +: KEY_W]) asc_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe <= '0;
            xpipe <= '0;
        end else begin
            vpipe <= {vpipe[LAT-2:0], in_valid};
            xpipe <= {xpipe[LAT-2:0], in_x};
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vpipe[LAT-1]); // R2

    AST_KEYS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> asc_ok); // R3

    AST_WORDS_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_x == xpipe[LAT-1])); // R5

endmodule

bind tag_sorter tag_sorter_chk #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .KEY_W     (KEY_W),
    .KEY_LSB   (KEY_LSB)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_words  (in_words),
    .out_valid (out_valid),
    .out_words (out_words)
);

// File: tb/tag_sorter_tb_top.sv
`timescale 1ns/1ps
module tag_sorter_tb_top;

    localparam int N    = 16;
    localparam int W    = 32;
    localparam int KW   = 4;
    localparam int KL   = 4;
    localparam int LAT  = 11;
    localparam int MAXC = 512;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_words = '0;
    logic           out_valid;
    logic [N*W-1:0] out_words;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc   = 0;
    bit  done  = 1'b0;

    logic           exp_v   [MAXC];
    logic [N*W-1:0] exp_w   [MAXC];
    string          exp_tag [MAXC];

    always #2 clk = ~clk;

    tag_sorter #(
        .NUM_WORDS (N),
        .WORD_W    (W),
        .KEY_W     (KW),
        .KEY_LSB   (KL)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_words  (in_words),
        .out_valid (out_valid),
        .out_words (out_words)
    );

    // Stable bucket order by key: lower key first, then lower input slot.
    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] w);
        logic [N*W-1:0] r;
        int o;
        r = '0;
        o = 0;
        for (int k = 0; k < (1 << KW); k++) begin
            for (int i = 0; i < N; i++) begin
                if (int'(w[i*W + KL +: KW]) == k) begin
                    r[o*W +: W] = w[i*W +: W];
                    o++;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [W-1:0] with_key(input logic [W-1:0] base, input int key);
        logic [W-1:0] v;
        v = base;
        v[KL +: KW] = KW'(key);
        return v;
    endfunction

    task automatic check_out();
        int   m;
        logic ev;
        m  = cyc - LAT;
        ev = (m >= 0) ? exp_v[m] : 1'b0;
        n_chk++;
        if (out_valid !== ev) begin
            n_bad++;
            $display("FAIL R2 out_valid at cycle %0d: actual %b expected %b", cyc, out_valid, ev);
        end
        if (ev === 1'b1) begin
            n_chk++;
            if (out_words !== exp_w[m]) begin
                n_bad++;
                $display("FAIL %s words at cycle %0d: actual %h expected %h",
                         exp_tag[m], cyc, out_words, exp_w[m]);
            end
        end
    endtask

    task automatic step(input logic v, input logic [N*W-1:0] w, input string tag);
        in_valid     = v;
        in_words     = w;
        exp_v[cyc]   = v;
        exp_w[cyc]   = ref_sort(w);
        exp_tag[cyc] = tag;
        @(negedge clk);
        cyc++;
        check_out();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, '0, "R2");
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] w;
        logic [N*W-1:0] w2;
        for (int c = 0; c < MAXC; c++) begin
            exp_v[c] = 1'b0;
            exp_w[c] = '0;
            exp_tag[c] = "";
        end

        // R1: outputs idle under reset.
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_words = '1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            n_chk++;
            if (out_valid !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 out_valid in reset: actual %b expected 0", out_valid);
            end
        end
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // R3 R5 R6: back-to-back random sets (4-bit keys give many duplicates, R4).
        for (int s = 0; s < 24; s++) begin
            for (int i = 0; i < N; i++) w[i*W +: W] = $urandom();
            step(1'b1, w, "R3 R4 R5 R6");
        end

        // R2: gaps and isolated sets.
        idle(3);
        for (int i = 0; i < N; i++) w[i*W +: W] = $urandom();
        step(1'b1, w, "R2 R3");
        idle(2);
        for (int i = 0; i < N; i++) w[i*W +: W] = $urandom();
        step(1'b1, w, "R2 R3");
        idle(1);

        // R8: all keys equal -> identity.
        for (int i = 0; i < N; i++) w[i*W +: W] = with_key($urandom(), 9);
        step(1'b1, w, "R8");
        for (int i = 0; i < N; i++) w[i*W +: W] = with_key($urandom(), 0);
        step(1'b1, w, "R8");

        // R9: strictly descending keys -> full reversal.
        for (int i = 0; i < N; i++) w[i*W +: W] = with_key($urandom(), 15 - i);
        step(1'b1, w, "R9");

        // R4: few distinct keys, many ties with distinct payloads.
        for (int i = 0; i < N; i++) w[i*W +: W] = with_key(32'(i) << 16, (i * 7) % 3);
        step(1'b1, w, "R4");
        for (int i = 0; i < N; i++) w[i*W +: W] = with_key(32'(N - i) << 20, (i < 8) ? 5 : 2);
        step(1'b1, w, "R4");

        // R7: same keys, different bits outside the key field.
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] b;
            b = $urandom();
            b[3:0] = 4'(15 - i);
            w[i*W +: W]  = with_key(b, (i * 5) % 16);
            b = ~b;
            b[3:0] = 4'(i);
            w2[i*W +: W] = with_key(b, (i * 5) % 16);
        end
        step(1'b1, w, "R7");
        step(1'b1, w2, "R7");

        // Drain.
        idle(LAT + 3);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule